// File: doc/BRIEF.md
# Three-Wire Serial Control Slave

This block is the slave end of a three-wire control bus with a clock line, a data line and an identify line. A bus master uses it to program a small bank of byte-wide function registers in a peripheral. While identify is low the master clocks in an address byte. It raises identify and clocks in a data byte. It then ends the transfer with a short low pulse on identify. The addressed register takes the new byte only on that closing pulse, so a half-finished transfer never disturbs a live setting. One fixed address code is a read command. For that code the slave answers on the data line with the latched state of two digital input pins that idle high.

All bus lines and the two pins pass through two-flop synchronisers into the system clock domain, where their edges are detected. The bus clock must therefore be slow against the system clock. The committed register values are always visible as a flat vector. A one-cycle strobe and an index mark each update. These are plain control pins with no handshake, so there is no back-pressure: a consumer that needs a change must take it in the strobe cycle, or read the register vector later.

Top module: `tri_wire_ctl_slave`

## Requirements
- R1: Bits are taken on rising edges of the bus clock, least significant bit first. The address is the last eight bits shifted while identify is low. Any earlier padding bits are dropped, whether the address phase is 8 or 16 bits long.
- R2: The data byte is the last eight bits shifted while identify is high, after the address phase.
- R3: A register keeps its old value through the whole data phase. It takes the data byte one cycle after the falling edge of identify that ends the data phase. In that same cycle `upd_stb` is high for exactly one cycle and `upd_idx` gives the register index.
- R4: A write takes effect only when address bits [7:4] equal `DEV_SEL` (default 4). Any other value leaves every register unchanged and raises no strobe.
- R5: Address bits [3:0] select register i, which appears at `reg_vals[8*i+7:8*i]`. An index of `NUM_FUNCS` (default 4) or more writes nothing.
- R6: If the address phase or the data phase received fewer than eight bits, no register is written.
- R7: Address `READ_CODE` (default 0x47) is a read. The two pin levels are latched when identify rises. Before the k-th data-phase clock rise (k counted from 0), `bus_dat_pull_low` is 1 when k < 2 and pin k was latched low, and 0 otherwise. A read writes no register.
- R8: If a bus-clock rising edge and an identify edge land in the same synchronised cycle, the clock edge is discarded and no bit is shifted.
- R9: After reset all registers are 0, `upd_stb` is 0 and the data line is released.
- R10: A rise of identify with no bits shifted since its last fall (the end of the closing pulse) does not open a data phase. Transfers may therefore follow one another directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_clk | input | 1 | Serial bus clock, idles high |
| bus_dat | input | 1 | Serial bus data |
| bus_ident | input | 1 | Identify line, idles high |
| dig_in | input | 2 | Digital input pins, idle high |
| bus_dat_pull_low | output | 1 | 1 = drive the data line low during a read |
| reg_vals | output | NUM_FUNCS*8 | Committed function registers, register i in bits [8i+7:8i] |
| upd_stb | output | 1 | One-cycle pulse when a register is written |
| upd_idx | output | 4 | Index of the register written with `upd_stb` |

## Verification
The two functions that can coincide are shifting a bit on a bus-clock rise and acting on an identify edge, which either closes the address phase or commits the data. The bench provokes this by changing the bus clock and identify at the same system-clock edge, so both pass through the synchronisers together. One extra data bit of value 1 rides on that clock edge. The committed register is judged against the original byte; a design that shifts the bit before committing would instead store the byte moved down one place with a 1 in the top bit.

// File: rtl/tws_pkg.sv
package tws_pkg;
  localparam int BYTE_W = 8;
  localparam int NIB_W  = 4;
  localparam int CNT_W  = 4;   // counts 0..BYTE_W, saturating
  localparam int PIN_N  = 2;
endpackage

// File: rtl/tws_sync.sv
module tws_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= {STAGES{RST_VAL}};
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/tws_frame.sv
module tws_frame
  import tws_pkg::*;
#(
  parameter logic [NIB_W-1:0]  DEV_SEL   = 4'h4,
  parameter int                NUM_FUNCS = 4,
  parameter logic [BYTE_W-1:0] READ_CODE = 8'h47
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_clk,
  input  logic              s_dat,
  input  logic              s_id,
  input  logic [PIN_N-1:0]  s_pins,
  output logic              commit_vld,
  output logic [NIB_W-1:0]  commit_idx,
  output logic [BYTE_W-1:0] commit_data,
  output logic              sda_low
);
  logic              p_clk, p_id;
  logic              in_data, addr_ok, rd_q;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] shreg, addr_q;
  logic [PIN_N-1:0]  pin_q;

  logic clk_rise, id_rise, id_fall, byte_full, wr_hit;
  assign clk_rise  = s_clk & ~p_clk;
  assign id_rise   = s_id & ~p_id;
  assign id_fall   = ~s_id & p_id;
  assign byte_full = (cnt == CNT_W'(BYTE_W));
  assign wr_hit    = addr_ok && (addr_q[BYTE_W-1:NIB_W] == DEV_SEL)
                  && (int'(addr_q[NIB_W-1:0]) < NUM_FUNCS) && (addr_q != READ_CODE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_clk <= 1'b1;  p_id <= 1'b1;
      in_data <= 1'b0; addr_ok <= 1'b0; rd_q <= 1'b0;
      cnt <= '0; shreg <= '0; addr_q <= '0; pin_q <= '1;
      commit_vld <= 1'b0; commit_idx <= '0; commit_data <= '0;
    end else begin
      p_clk <= s_clk;
      p_id  <= s_id;
      commit_vld <= 1'b0;
      if (id_rise) begin
        // identify edges take priority; a coincident clock edge is dropped
        if (!in_data && cnt != '0) begin
          addr_q  <= shreg;
          addr_ok <= byte_full;
          rd_q    <= byte_full && (shreg == READ_CODE);
          pin_q   <= s_pins;
          in_data <= 1'b1;
          cnt     <= '0;
          shreg   <= '0;
        end
      end else if (id_fall) begin
        if (in_data && byte_full && wr_hit) begin
          commit_vld  <= 1'b1;
          commit_idx  <= addr_q[NIB_W-1:0];
          commit_data <= shreg;
        end
        in_data <= 1'b0;
        rd_q    <= 1'b0;
        cnt     <= '0;
        shreg   <= '0;
      end else if (clk_rise) begin
        shreg <= {s_dat, shreg[BYTE_W-1:1]};
        if (!byte_full) cnt <= cnt + 1'b1;
      end
    end
  end

  // Read answer: bit k presented before the k-th clock rise of the data phase
  assign sda_low = in_data && rd_q && (cnt < CNT_W'(PIN_N)) && !pin_q[cnt[0]];

  a_r8_edge_drops_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (id_rise || id_fall) |=> (cnt == '0));
  a_r3_commit_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
    commit_vld |-> $past(id_fall));
  a_r7_drive_while_high: assert property (@(posedge clk) disable iff (!rst_n)
    sda_low |-> $past(s_id));
  a_r7_read_never_commits: assert property (@(posedge clk) disable iff (!rst_n)
    commit_vld |-> !$past(rd_q));
endmodule

// File: rtl/tws_regbank.sv
module tws_regbank
  import tws_pkg::*;
#(
  parameter int NUM_FUNCS = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_vld,
  input  logic [NIB_W-1:0]            wr_idx,
  input  logic [BYTE_W-1:0]           wr_data,
  output logic [NUM_FUNCS*BYTE_W-1:0] regs,
  output logic                        upd_stb,
  output logic [NIB_W-1:0]            upd_idx
);
  logic [BYTE_W-1:0]    mem [NUM_FUNCS];
  logic [NUM_FUNCS-1:0] we;

  for (genvar i = 0; i < NUM_FUNCS; i++) begin : g_reg
    assign we[i] = wr_vld && (wr_idx == NIB_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     mem[i] <= '0;
      else if (we[i]) mem[i] <= wr_data;
    end
    assign regs[i*BYTE_W +: BYTE_W] = mem[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upd_stb <= 1'b0;
      upd_idx <= '0;
    end else begin
      upd_stb <= |we;
      if (|we) upd_idx <= wr_idx;
    end
  end

  a_r5_single_target: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(we));
  a_r3_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
    !(|we) |=> $stable(regs));
  a_r3_strobe_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    upd_stb |=> !upd_stb);
endmodule

// File: rtl/tri_wire_ctl_slave.sv
module tri_wire_ctl_slave
  import tws_pkg::*;
#(
  parameter logic [NIB_W-1:0]  DEV_SEL     = 4'h4,
  parameter int                NUM_FUNCS   = 4,
  parameter logic [BYTE_W-1:0] READ_CODE   = 8'h47,
  parameter int                SYNC_STAGES = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        bus_clk,
  input  logic                        bus_dat,
  input  logic                        bus_ident,
  input  logic [PIN_N-1:0]            dig_in,
  output logic                        bus_dat_pull_low,
  output logic [NUM_FUNCS*BYTE_W-1:0] reg_vals,
  output logic                        upd_stb,
  output logic [NIB_W-1:0]            upd_idx
);
  localparam int IN_W = PIN_N + 3;

  logic [IN_W-1:0]   raw, synced;
  logic              c_vld;
  logic [NIB_W-1:0]  c_idx;
  logic [BYTE_W-1:0] c_data;

  assign raw = {dig_in, bus_ident, bus_dat, bus_clk};

  tws_sync #(.W(IN_W), .STAGES(SYNC_STAGES), .RST_VAL({IN_W{1'b1}})) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw), .q(synced)
  );

  tws_frame #(.DEV_SEL(DEV_SEL), .NUM_FUNCS(NUM_FUNCS), .READ_CODE(READ_CODE)) u_frame (
    .clk(clk), .rst_n(rst_n),
    .s_clk(synced[0]), .s_dat(synced[1]), .s_id(synced[2]),
    .s_pins(synced[IN_W-1:3]),
    .commit_vld(c_vld), .commit_idx(c_idx), .commit_data(c_data),
    .sda_low(bus_dat_pull_low)
  );

  tws_regbank #(.NUM_FUNCS(NUM_FUNCS)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .wr_vld(c_vld), .wr_idx(c_idx), .wr_data(c_data),
    .regs(reg_vals), .upd_stb(upd_stb), .upd_idx(upd_idx)
  );

  a_r9_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (!upd_stb && !bus_dat_pull_low));
endmodule

// File: tb/tri_wire_ctl_slave_bench.sv
`timescale 1ns/1ps
module tri_wire_ctl_slave_bench;
  localparam int NF = 4;
  localparam int GAP = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_clk = 1'b1, bus_dat = 1'b1, bus_ident = 1'b1;
  logic [1:0] dig_in = 2'b11;
  logic bus_dat_pull_low, upd_stb;
  logic [NF*8-1:0] reg_vals;
  logic [3:0] upd_idx;

  always #2 clk = ~clk;

  tri_wire_ctl_slave u_tri_wire_ctl_slave (
    .clk(clk), .rst_n(rst_n), .bus_clk(bus_clk), .bus_dat(bus_dat),
    .bus_ident(bus_ident), .dig_in(dig_in), .bus_dat_pull_low(bus_dat_pull_low),
    .reg_vals(reg_vals), .upd_stb(upd_stb), .upd_idx(upd_idx)
  );

  int checks = 0, fails = 0, strobes = 0;
  bit finished = 0;
  logic [3:0] last_idx = '0;
  logic [NF*8-1:0] exp_regs = '0;
  int exp_strobes = 0;

  always @(negedge clk) if (upd_stb) begin strobes++; last_idx = upd_idx; end

  // {address, data, padding bits ahead of the address}
  localparam logic [23:0] VEC [8] = '{
    {8'h40, 8'h3C, 8'd0}, {8'h41, 8'hA5, 8'd8}, {8'h43, 8'hFF, 8'd3},
    {8'h42, 8'h01, 8'd0}, {8'h50, 8'h77, 8'd0}, {8'h44, 8'h66, 8'd0},
    {8'h40, 8'hC3, 8'd5}, {8'h34, 8'h99, 8'd8}
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic gap();
    repeat (GAP) @(negedge clk);
  endtask

  task automatic bit_out(input logic b);
    bus_clk = 1'b0; bus_dat = b; gap();
    bus_clk = 1'b1; gap();
  endtask

  task automatic xfer(input logic [7:0] addr, input logic [7:0] data, input int npad,
                      input int nab, input int ndb, input bit collide,
                      input logic [1:0] dig_after, output logic [2:0] rd);
    rd = '0;
    bus_ident = 1'b0; gap();
    for (int i = 0; i < npad; i++) bit_out(i[0]);
    for (int i = 0; i < nab; i++) bit_out(addr[i]);
    bus_ident = 1'b1; gap();
    dig_in = dig_after; gap();
    for (int i = 0; i < ndb; i++) begin
      if (i < 3) rd[i] = bus_dat_pull_low;
      bit_out(data[i]);
    end
    check(reg_vals == exp_regs, "R3 hold during data phase", reg_vals, exp_regs);
    if (collide) begin
      bus_clk = 1'b0; bus_dat = 1'b1; gap();
      bus_clk = 1'b1; bus_ident = 1'b0; gap();
    end else begin
      bus_ident = 1'b0; gap();
    end
    bus_ident = 1'b1; gap(); gap();
  endtask

  task automatic model(input logic [7:0] addr, input logic [7:0] data, input int nab, input int ndb);
    if (nab == 8 && ndb == 8 && addr[7:4] == 4'h4 && addr[3:0] < NF) begin
      exp_regs[addr[3:0]*8 +: 8] = data;
      exp_strobes++;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [2:0] rd;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    check(reg_vals == '0, "R9 regs after reset", reg_vals, '0);
    check(upd_stb == 1'b0, "R9 strobe after reset", upd_stb, 0);
    check(bus_dat_pull_low == 1'b0, "R9 line released", bus_dat_pull_low, 0);
    gap();

    // Table walk: R1 padding, R2 data, R4 select, R5 index, R10 back to back
    for (int v = 0; v < 8; v++) begin
      logic [7:0] a, d, p;
      {a, d, p} = VEC[v];
      xfer(a, d, int'(p), 8, 8, 1'b0, 2'b11, rd);
      model(a, d, 8, 8);
      check(reg_vals == exp_regs, "R1 R2 R4 R5 R10 registers", reg_vals, exp_regs);
      check(strobes == exp_strobes, "R3 R4 R5 strobe count", strobes, exp_strobes);
      if (a[7:4] == 4'h4 && a[3:0] < NF)
        check(last_idx == a[3:0], "R3 strobe index", last_idx, a[3:0]);
    end

    // R6 short address phase, then short data phase
    xfer(8'h42, 8'h11, 0, 5, 8, 1'b0, 2'b11, rd);
    check(reg_vals == exp_regs, "R6 short address", reg_vals, exp_regs);
    xfer(8'h42, 8'h11, 0, 8, 5, 1'b0, 2'b11, rd);
    check(reg_vals == exp_regs, "R6 short data", reg_vals, exp_regs);
    check(strobes == exp_strobes, "R6 no strobe", strobes, exp_strobes);

    // R7 read: pins latched at identify rise, changed afterwards
    dig_in = 2'b10; gap();
    xfer(8'h47, 8'hFF, 0, 8, 8, 1'b0, 2'b01, rd);
    check(rd == 3'b001, "R7 read pins 10", rd, 3'b001);
    dig_in = 2'b00; gap();
    xfer(8'h47, 8'h00, 2, 8, 8, 1'b0, 2'b11, rd);
    check(rd == 3'b011, "R7 read pins 00", rd, 3'b011);
    check(reg_vals == exp_regs, "R7 read writes nothing", reg_vals, exp_regs);
    check(strobes == exp_strobes, "R7 read no strobe", strobes, exp_strobes);
    check(bus_dat_pull_low == 1'b0, "R7 released after read", bus_dat_pull_low, 0);

    // R8 clock rise coincident with the closing identify fall
    xfer(8'h41, 8'h5A, 0, 8, 8, 1'b1, 2'b11, rd);
    model(8'h41, 8'h5A, 8, 8);
    check(reg_vals[15:8] == 8'h5A, "R8 coincident edge dropped", reg_vals[15:8], 8'h5A);
    check(strobes == exp_strobes, "R8 strobe count", strobes, exp_strobes);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule